// File: doc/BRIEF.md
# Serial Flash Array-Read Target

This block is the device end of a serial flash read path. A host selects it by pulling the active-low chip select down, then clocks in an 8-bit read command and a 24-bit start address, both most significant bit first. Depending on the command, the host also clocks in zero, one or two filler bytes. After that, every further serial clock returns one bit of the internal byte array on the serial output. The array address moves forward by one after each byte and wraps to zero past the top, so a single command can stream the whole array and keep going.

All four serial pins are oversampled by a fast system clock. Incoming data is taken on serial-clock rising edges. The output bit and its enable change on falling edges (SPI mode 0). The array is a block-RAM-style memory preloaded with a computed pattern, so the read path can be exercised without a write path. Any command byte other than the three read codes makes the block go quiet until chip select goes high again.

Top module: `spi_flash_read_target`

## Requirements
- R1: The command bytes 0x03, 0x0B and 0x1B, shifted in MSB first on the first 8 serial-clock rising edges after chip select falls, each start an array read.
- R2: The 24 bits on the next 24 rising edges form the start address, MSB first. Only the low ADDR_W bits select the array entry.
- R3: After the address, command 0x1B skips 16 rising edges, 0x0B skips 8 and 0x03 skips none. The output enable stays low during the command, address and filler bits.
- R4: On the falling edge that follows the last command, address or filler bit, the output enable rises and the MSB of the addressed byte is driven. Each later falling edge drives the next lower bit.
- R5: After bit 0 of a byte, the next falling edge drives bit 7 of the byte at the next address, with no gap, for as long as the clock runs.
- R6: After the byte at address 2^ADDR_W-1, streaming continues at address 0 with no extra clock.
- R7: Raising chip select at any bit position ends the read. The output enable is low within 3 system clocks.
- R8: Any other command byte keeps the output enable low until chip select rises. The next selection accepts a read command normally.
- R9: After reset, both the serial output and the output enable are low.
- R10: Array entry i holds ((i*37 + 11) mod 256) XOR (i div 256), truncated to 8 bits.
- R11: Serial-clock edges while chip select is high have no effect. A later read behaves as if they never happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | High when spi_miso should be driven onto the line |

## Verification
Each serial pin passes two synchronizer stages and one edge-detect stage. An output bit or enable change therefore lands 3 system clocks after the serial-clock or chip-select transition that caused it. The bench holds each serial-clock phase for 8 system clocks and compares the output and enable just before each rising edge, long after they have settled, against a behavioural bit stream built from the start address and the array formula. After raising chip select, the bench waits 4 system clocks before it requires the enable to be low.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } rd_state_t;

  localparam logic [7:0] CMD_READ_SLOW = 8'h03;
  localparam logic [7:0] CMD_READ_FAST = 8'h0B;
  localparam logic [7:0] CMD_READ_TOP  = 8'h1B;

  function automatic logic is_read_cmd(input logic [7:0] c);
    return (c == CMD_READ_SLOW) || (c == CMD_READ_FAST) || (c == CMD_READ_TOP);
  endfunction

  function automatic logic [1:0] filler_bytes(input logic [7:0] c);
    case (c)
      CMD_READ_TOP:  return 2'd2;
      CMD_READ_FAST: return 2'd1;
      default:       return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] preload_byte(input int unsigned i);
    int unsigned v;
    v = ((i * 37 + 11) % 256) ^ (i / 256);
    return v[7:0];
  endfunction

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int            WIDTH   = 3,
  parameter int            STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_prev
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dout_prev <= RST_VAL;
    else     dout_prev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem import spi_rd_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(preload_byte(i));
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $stable(rd_addr) |=> $stable(rd_data));

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl import spi_rd_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_bit,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso_q,
  output logic              miso_oe_q
);

  rd_state_t         state;
  logic [2:0]        bit_cnt;
  logic [1:0]        byte_cnt;
  logic [1:0]        fill_need;
  logic [23:0]       sh;
  logic [23:0]       sh_next;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        obuf;

  assign sh_next = {sh[22:0], mosi_bit};
  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OPC;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      fill_need <= '0;
      sh        <= '0;
      addr      <= '0;
      obuf      <= '0;
      miso_q    <= 1'b0;
      miso_oe_q <= 1'b0;
    end else if (!cs_act) begin
      state     <= ST_OPC;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      miso_oe_q <= 1'b0;
    end else if (sck_rise) begin
      case (state)
        ST_OPC: begin
          sh      <= sh_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_cnt <= '0;
            if (is_read_cmd(sh_next[7:0])) begin
              state     <= ST_ADDR;
              fill_need <= filler_bytes(sh_next[7:0]);
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR: begin
          sh      <= sh_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt == 2'd2) begin
              addr     <= sh_next[ADDR_W-1:0];
              byte_cnt <= '0;
              state    <= (fill_need == 2'd0) ? ST_DATA : ST_DUMMY;
            end else begin
              byte_cnt <= byte_cnt + 2'd1;
            end
          end
        end
        ST_DUMMY: begin
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt == fill_need - 2'd1) begin
              byte_cnt <= '0;
              state    <= ST_DATA;
            end else begin
              byte_cnt <= byte_cnt + 2'd1;
            end
          end
        end
        default: ;
      endcase
    end else if (sck_fall && state == ST_DATA) begin
      bit_cnt   <= bit_cnt + 3'd1;
      miso_oe_q <= 1'b1;
      if (bit_cnt == 3'd0) begin
        obuf   <= rd_data;
        miso_q <= rd_data[7];
        addr   <= addr + 1'b1;
      end else begin
        miso_q <= obuf[3'd7 - bit_cnt];
      end
    end
  end

  assert_oe_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_oe_q);

  assert_oe_in_data_R4: assert property (@(posedge clk) disable iff (rst)
    miso_oe_q |-> (state == ST_DATA));

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_act && sck_fall && state == ST_DATA && bit_cnt == 3'd0)
      |=> (miso_q == $past(rd_data[7])));

  assert_ignore_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE && cs_act) |=> (state == ST_IGNORE && !miso_oe_q));

  assert_filler_need_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DUMMY) |-> (fill_need != 2'd0));

  assert_rise_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    sck_rise |=> !sck_rise);

endmodule

// File: rtl/spi_flash_read_target.sv
module spi_flash_read_target #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);

  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b100;

  logic [PIN_N-1:0]  pins_s;
  logic [PIN_N-1:0]  pins_p;
  logic              cs_act;
  logic              sck_rise;
  logic              sck_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  spi_rd_sync #(
    .WIDTH   (PIN_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .din       ({spi_cs_n, spi_sck, spi_mosi}),
    .dout      (pins_s),
    .dout_prev (pins_p)
  );

  assign cs_act   = ~pins_s[2];
  assign sck_rise =  pins_s[1] & ~pins_p[1];
  assign sck_fall = ~pins_s[1] &  pins_p[1];

  spi_rd_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (8)
  ) u_mem (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  spi_rd_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi_bit  (pins_s[0]),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .miso_q    (spi_miso),
    .miso_oe_q (spi_miso_oe)
  );

endmodule

// File: tb/spi_flash_read_target_tb.sv
module spi_flash_read_target_tb;

  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1;
  logic spi_sck  = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic spi_miso_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_flash_read_target #(.ADDR_W(ADDR_W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
  );

  function automatic int exp_byte(input int a);
    return (((a * 37) + 11) & 255) ^ ((a >> 8) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    wait_half();
  endtask

  task automatic cs_end();
    wait_half();
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(spi_miso_oe == 1'b0, "R7 oe low after deselect", spi_miso_oe, 0);
    repeat (3) wait_half();
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      wait_half();
      check(spi_miso_oe == 1'b0, req, spi_miso_oe, 0);
      spi_sck = 1'b1;
      wait_half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic recv_bits(input int start, input int nbits, input string req);
    for (int k = 0; k < nbits; k++) begin
      int a;
      int e;
      a = (start + k / 8) % DEPTH;
      e = (exp_byte(a) >> (7 - (k % 8))) & 1;
      spi_mosi = 1'b1;
      wait_half();
      check(spi_miso_oe == 1'b1, {req, " oe"}, spi_miso_oe, 1);
      check(spi_miso == e[0], req, spi_miso, e);
      spi_sck = 1'b1;
      wait_half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [23:0] a24, input int nbits,
                         input string req);
    int nfill;
    nfill = (cmd == 8'h1B) ? 2 : (cmd == 8'h0B) ? 1 : 0;
    cs_begin();
    send_byte(cmd, "R1 oe low in command");
    send_byte(a24[23:16], "R2 oe low in address");
    send_byte(a24[15:8],  "R2 oe low in address");
    send_byte(a24[7:0],   "R2 oe low in address");
    for (int f = 0; f < nfill; f++) send_byte(8'hA5, "R3 oe low in filler");
    recv_bits(int'(a24) % DEPTH, nbits, req);
    cs_end();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R9 reset state
    check(spi_miso_oe == 1'b0, "R9 oe after reset", spi_miso_oe, 0);
    check(spi_miso == 1'b0, "R9 miso after reset", spi_miso, 0);

    // R1 R4 R5 R10: slow read, four bytes
    do_read(8'h03, 24'h000010, 32, "R1 R4 R5 R10 read 03h");
    // R2 R3: one filler byte, high address bits dropped
    do_read(8'h0B, 24'hAB0123, 24, "R2 R3 read 0Bh");
    // R3 R6: two filler bytes, wrap past top address
    do_read(8'h1B, 24'h0003FE, 32, "R3 R6 read 1Bh wrap");
    // R6 wrap from the very last byte with no filler
    do_read(8'h03, 24'h0003FF, 16, "R6 wrap last byte");
    // R7: partial byte end
    do_read(8'h03, 24'h000200, 11, "R7 partial read");

    // R8: unsupported command
    cs_begin();
    send_byte(8'h9F, "R8 oe low on bad command");
    for (int b = 0; b < 5; b++) send_byte(8'h03, "R8 oe stays low");
    cs_end();
    do_read(8'h0B, 24'h000077, 16, "R8 read after bad command");

    // R11: serial clock while deselected
    for (int i = 0; i < 13; i++) begin
      spi_mosi = i[0];
      wait_half();
      spi_sck = 1'b1;
      wait_half();
      spi_sck = 1'b0;
      check(spi_miso_oe == 1'b0, "R11 oe low while deselected", spi_miso_oe, 0);
    end
    do_read(8'h03, 24'h000005, 16, "R11 read after idle clocks");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule